// File: doc/BRIEF.md
# Prescaled Voltage Ramp Wait Timer

This block times the settling wait that follows a regulator voltage step. A 16-bit setting word holds two 8-bit ramp settings, one for a rising step and one for a falling step. Each setting pairs a 6-bit repeat count with a 2-bit prescaler code. The codes pick uneven divisors of 64, 256, 512 or 2048 system clock cycles, so a short field still covers waits from tens to about 129,000 cycles.

A start pulse, together with a direction input, takes the matching setting and launches the wait. The wait runs for count × divisor clock cycles. While it runs, a busy output is high. A single-cycle done pulse marks its end. A count field of zero means the setting holds no valid ramp time, and the timer reports done at once. A start that arrives during a running wait discards that wait and begins again from the new setting.

Top module: `ramp_wait_timer`

## Requirements
- R1: After reset, and with no start pulse, busy and done are both low.
- R2: The rising-step setting is cfg_word[7:0] and the falling-step setting is cfg_word[15:8]. dir_down = 0 selects the rising one. Inside a setting, bits [5:0] hold the count and bits [7:6] hold the prescaler code.
- R3: Prescaler codes 0, 1, 2 and 3 select divisors of 64, 256, 512 and 2048 clock cycles.
- R4: Take the rising edge that samples start high as edge 0. With a nonzero count, done is high in the cycle that follows edge count × divisor.
- R5: With a nonzero count, busy is high from the cycle after the start edge up to the cycle in which done is high. In that cycle busy is low.
- R6: A count field of zero means zero wait, whatever the prescaler code. Done is high in the cycle right after the start edge, and busy stays low.
- R7: Done is high for exactly one cycle per completed wait.
- R8: A start while busy is high abandons the running wait. Timing restarts from the new start edge, using the setting that the new dir_down selects.
- R9: The block reads cfg_word and dir_down only on the start edge. Changes to them during a wait do not alter its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all timing counts its rising edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 16 | Two ramp settings: rising step in [7:0], falling step in [15:8] |
| start | input | 1 | Launches or restarts a wait when high at a rising edge |
| dir_down | input | 1 | Selects the falling-step setting when 1 |
| busy | output | 1 | High while a wait is counting |
| done | output | 1 | One-cycle pulse at the end of a wait |

## Verification
Any fault inside the timer shows up in when done appears, because done is the only result the block gives. A wrong prescaler reload or a wrong divisor decode shifts done by a multiple of the base period. That shift shows up in the first wait that uses the affected code, after no more than 2048 cycles per count step. A tick counter that is off by one moves done by a whole divisor period. Stale captured settings show up as a wrong length after a restart, or after cfg_word changes during a wait. A broken zero-count path shows up one cycle after start, as a missing done pulse or a busy pulse that should not be there.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

    localparam int RAMP_CNT_W     = 6;
    localparam int RAMP_PSC_W     = 2;
    localparam int RAMP_BASE_LOG2 = 6;
    localparam int RAMP_PRE_W     = RAMP_BASE_LOG2 + 5;

    // extra left shift on top of the base divisor for each prescaler code
    function automatic int psc_shift(input int code);
        case (code)
            0:       return 0;
            1:       return 2;
            2:       return 3;
            default: return 5;
        endcase
    endfunction

endpackage

// File: rtl/ramp_field_sel.sv
module ramp_field_sel #(
    parameter int CNT_W = ramp_pkg::RAMP_CNT_W,
    parameter int PSC_W = ramp_pkg::RAMP_PSC_W,
    localparam int FIELD_W = CNT_W + PSC_W,
    localparam int NFIELD  = 2
) (
    input  logic [NFIELD*FIELD_W-1:0] cfg_word,
    input  logic                      dir_down,
    output logic [CNT_W-1:0]          cnt,
    output logic [PSC_W-1:0]          psc
);

    logic [FIELD_W-1:0] fld [NFIELD];
    logic [FIELD_W-1:0] sel;

    for (genvar f = 0; f < NFIELD; f++) begin : g_fld
        assign fld[f] = cfg_word[f*FIELD_W +: FIELD_W];
    end

    assign sel = fld[dir_down];
    assign cnt = sel[CNT_W-1:0];
    assign psc = sel[FIELD_W-1 -: PSC_W];

endmodule

// File: rtl/ramp_div_decode.sv
module ramp_div_decode #(
    parameter int PSC_W     = ramp_pkg::RAMP_PSC_W,
    parameter int BASE_LOG2 = ramp_pkg::RAMP_BASE_LOG2,
    parameter int PRE_W     = ramp_pkg::RAMP_PRE_W,
    localparam int NCODE    = 1 << PSC_W
) (
    input  logic [PSC_W-1:0] psc,
    output logic [PRE_W-1:0] reload
);

    logic [PRE_W-1:0] lut [NCODE];

    // each entry is divisor - 1 so the prescaler counts down to zero
    for (genvar g = 0; g < NCODE; g++) begin : g_lut
        localparam int SH = BASE_LOG2 + ramp_pkg::psc_shift(g);
        assign lut[g] = PRE_W'((64'd1 << SH) - 64'd1);
    end

    assign reload = lut[psc];

endmodule

// File: rtl/ramp_core.sv
module ramp_core #(
    parameter int CNT_W = ramp_pkg::RAMP_CNT_W,
    parameter int PRE_W = ramp_pkg::RAMP_PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cnt,
    input  logic [PRE_W-1:0] reload,
    output logic             busy,
    output logic             done
);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] tick;
        logic [PRE_W-1:0] reload;
    } core_state_t;

    core_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (start) begin
            if (cnt == '0) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end else begin
                s_d.busy   = 1'b1;
                s_d.pre    = reload;
                s_d.tick   = cnt;
                s_d.reload = reload;
            end
        end else if (s_q.busy) begin
            if (s_q.pre == '0) begin
                if (s_q.tick == CNT_W'(1)) begin
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end else begin
                    s_d.tick = s_q.tick - CNT_W'(1);
                    s_d.pre  = s_q.reload;
                end
            end else begin
                s_d.pre = s_q.pre - PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = s_q.busy;
    assign done = s_q.done;

endmodule

// File: rtl/ramp_wait_timer.sv
module ramp_wait_timer #(
    parameter int CNT_W     = ramp_pkg::RAMP_CNT_W,
    parameter int PSC_W     = ramp_pkg::RAMP_PSC_W,
    parameter int BASE_LOG2 = ramp_pkg::RAMP_BASE_LOG2,
    localparam int PRE_W    = BASE_LOG2 + 5,
    localparam int CFG_W    = 2 * (CNT_W + PSC_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             start,
    input  logic             dir_down,
    output logic             busy,
    output logic             done
);

    logic [CNT_W-1:0] sel_cnt;
    logic [PSC_W-1:0] sel_psc;
    logic [PRE_W-1:0] sel_reload;

    ramp_field_sel #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_sel (
        .cfg_word (cfg_word),
        .dir_down (dir_down),
        .cnt      (sel_cnt),
        .psc      (sel_psc)
    );

    ramp_div_decode #(.PSC_W(PSC_W), .BASE_LOG2(BASE_LOG2), .PRE_W(PRE_W)) u_div (
        .psc    (sel_psc),
        .reload (sel_reload)
    );

    ramp_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .cnt    (sel_cnt),
        .reload (sel_reload),
        .busy   (busy),
        .done   (done)
    );

endmodule

// File: rtl/ramp_wait_timer_chk.sv
module ramp_wait_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cfg_word,
    input logic        start,
    input logic        dir_down,
    input logic        busy,
    input logic        done
);

    logic [5:0] chk_cnt;
    assign chk_cnt = dir_down ? cfg_word[13:8] : cfg_word[5:0];

    assert_zero_immediate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && chk_cnt == 6'd0) |=> (done && !busy));

    assert_start_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && chk_cnt != 6'd0) |=> (busy && !done));

    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    assert_done_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) || $past(start)));

    assert_busy_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !$past(start)) |-> done);

endmodule

bind ramp_wait_timer ramp_wait_timer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_word (cfg_word),
    .start    (start),
    .dir_down (dir_down),
    .busy     (busy),
    .done     (done)
);

// File: tb/test_ramp_wait_timer.sv
`timescale 1ns/1ps
module test_ramp_wait_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_word = '0;
    logic        start = 1'b0;
    logic        dir_down = 1'b0;
    logic        busy, done;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    ramp_wait_timer i_ramp_wait_timer (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .start(start),
        .dir_down(dir_down), .busy(busy), .done(done)
    );

    typedef struct packed {
        logic [15:0] cfg;
        logic        dir;
        logic [17:0] n;
    } vec_t;

    // expected wait = count x divisor (codes 0..3 -> 64,256,512,2048)
    localparam vec_t VEC [8] = '{
        '{16'h0001, 1'b0, 18'd64},    // R2 R3 R4 code0 count1
        '{16'h0043, 1'b0, 18'd768},   // R3 code1 count3
        '{16'h8205, 1'b1, 18'd1024},  // R2 R3 falling field code2 count2
        '{16'h00C1, 1'b0, 18'd2048},  // R3 code3 count1
        '{16'h003F, 1'b0, 18'd4032},  // R4 largest count
        '{16'h05FF, 1'b1, 18'd320},   // R2 falling field beside full rising field
        '{16'h3FC0, 1'b0, 18'd0},     // R6 zero count, prescaler nonzero
        '{16'h00FF, 1'b1, 18'd0}      // R6 all-zero falling field
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called at the negedge right after the start edge
    task automatic measure(input int n, input string req);
        int  k = 0;
        bit  busy_ok = 1'b1;
        while (!done && k < 140000) begin
            if (!busy) busy_ok = 1'b0;
            @(negedge clk);
            k++;
        end
        check(k == n, req, k, n);
        check(!busy, {req, " busy low at done"}, busy, 0);
        if (n > 0) check(busy_ok, {req, " R5 busy through wait"}, busy_ok, 1);
        @(negedge clk);
        check(!done, {req, " R7 single pulse"}, done, 0);
    endtask

    task automatic launch(input logic [15:0] cfg, input logic dir);
        cfg_word = cfg;
        dir_down = dir;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done, "R1 in reset", {busy, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!busy && !done, "R1 after reset", {busy, done}, 0);

        foreach (VEC[i]) begin
            launch(VEC[i].cfg, VEC[i].dir);
            measure(int'(VEC[i].n), $sformatf("R4 vec%0d", i));
        end

        // R8: restart mid-wait with the other direction's setting
        launch(16'h0102, 1'b0);
        for (int j = 0; j < 50; j++) begin
            @(negedge clk);
        end
        check(busy && !done, "R8 running before restart", {busy, done}, 2);
        launch(16'h0102, 1'b1);
        measure(64, "R8 restart");

        // R9: setting and direction changes during a wait are ignored
        cfg_word = 16'h0001;
        dir_down = 1'b0;
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        cfg_word = 16'h3F3F;
        dir_down = 1'b1;
        measure(64, "R9 inputs ignored");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule